// File: doc/BRIEF.md
# Cascadable Serial Display Driver Register

This block is the digital core of a serial-fed display driver. Pattern bits arrive one at a time on a serial input and are captured on each rising clock edge by a 32-stage shift register. A bank of level-sensitive latches sits between the register and the 32 display outputs. The first 29 outputs drive anode segments. The last 3 outputs drive grid digits.

While the strobe is high, the latches pass the register contents straight through. When the strobe drops, they freeze the display pattern. A grid enable can blank the three grid outputs without touching the anodes.

The last register stage is repeated on a serial output. That output is retimed on the falling clock edge, so several devices can share one clock and one strobe and form a longer chain without a hold race. A power-on reset clears the register, the latches and the serial output.

Top module: `disp_serial_driver`

## Requirements
- R1: On every rising edge of `clk`, the bit on `din` enters stage 0 and each stage k moves to stage k+1. The bit shifted in first therefore sits in stage 31 after 32 edges.
- R2: While `rst` is high, every stage, every latch and `dout` are 0, so all anode and grid outputs are off.
- R3: While `strobe` is low, the latches hold. Shifting new data leaves `anode_o` and `grid_o` unchanged.
- R4: While `strobe` is high, each latch follows its stage, including changes made by rising edges during the strobe.
- R5: Latch i drives `anode_o[i]` for i = 0..28 (anode 1 to anode 29). Latch 29+j drives `grid_o[j]` for j = 0..2. A latched 1 means the output is on and a latched 0 means it is off.
- R6: With `grid_en` low, `grid_o` is 0 whatever the latches hold, and `anode_o` is unaffected. With `grid_en` high, `grid_o` follows its latches.
- R7: `dout` carries stage 31 and changes only on falling edges of `clk`. Just after a rising edge it still shows the stage-31 value from before that edge.
- R8: When `dout` of one device feeds `din` of a second device on the same clock, the pair acts as a 64-stage register. After 64 shifts and one strobe pulse, the later device shows the first 32 bits sent and the nearer device shows the last 32 bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; rising edge shifts, falling edge updates `dout` |
| rst | input | 1 | Active-high asynchronous power-on reset |
| din | input | 1 | Serial pattern input |
| strobe | input | 1 | Latch transparency control, active high |
| grid_en | input | 1 | Grid output enable, active high |
| anode_o | output | 29 | Anode outputs, 1 = on |
| grid_o | output | 3 | Grid outputs, 1 = on, gated by `grid_en` |
| dout | output | 1 | Serial cascade output, last stage retimed on the falling edge |

## Verification
The results fall due at different times:
- A shift reaches the register at the rising edge.
- With the strobe high, the shift reaches `anode_o` and `grid_o` in the same time step as that edge.
- Raising the strobe shows the register at once, with no clock needed.
- `dout` moves half a period after the rising edge, at the falling edge.

The bench drives the clock one pulse at a time. It samples one time unit after the edge or strobe change that makes a result due, and compares against its own 64-bit chain model and latch images. For R7 it also samples between the rising and the falling edge, to confirm that `dout` still holds the earlier value there.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int DEF_STAGES = 32;
  localparam int DEF_ANODES = 29;
endpackage

// File: rtl/disp_shift_reg.sv
module disp_shift_reg #(
  parameter int STAGES = disp_pkg::DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [STAGES-1:0] sreg
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sreg <= '0;
    else     sreg <= {sreg[STAGES-2:0], din};
  end

  // R1: each edge moves every stage up by one and loads din into stage 0
  p_shift_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sreg == {$past(sreg[STAGES-2:0]), $past(din)}));

  // R2: the register is empty when reset is released
  p_sreg_clr_r2: assert property (@(negedge rst) (sreg == '0));

endmodule

// File: rtl/disp_latch_bank.sv
module disp_latch_bank #(
  parameter int WIDTH = disp_pkg::DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             le,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      always_latch begin
        if (rst)     q[i] = 1'b0;
        else if (le) q[i] = d[i];
      end
    end
  endgenerate

  // R4: while the enable is high, the latches show their inputs
  p_transp_r4: assert property (@(posedge clk) disable iff (rst)
    le |-> (q == d));

  // R2: the latches are clear when reset is released
  p_latch_clr_r2: assert property (@(negedge rst) (q == '0));

endmodule

// File: rtl/disp_grid_gate.sv
module disp_grid_gate #(
  parameter int GRIDS = 3
) (
  input  logic             en,
  input  logic [GRIDS-1:0] lat,
  output logic [GRIDS-1:0] grid
);

  genvar j;
  generate
    for (j = 0; j < GRIDS; j++) begin : g_grid
      assign grid[j] = en & lat[j];
    end
  endgenerate

endmodule

// File: rtl/disp_cascade_out.sv
module disp_cascade_out (
  input  logic clk,
  input  logic rst,
  input  logic last_stage,
  output logic dout
);

  always_ff @(negedge clk or posedge rst) begin
    if (rst) dout <= 1'b0;
    else     dout <= last_stage;
  end

  // R7: at a rising edge, dout already equals the last stage from the
  // falling edge before it
  p_dout_r7: assert property (@(posedge clk) disable iff (rst)
    dout == last_stage);

endmodule

// File: rtl/disp_serial_driver.sv
module disp_serial_driver #(
  parameter int STAGES = disp_pkg::DEF_STAGES,
  parameter int ANODES = disp_pkg::DEF_ANODES
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       din,
  input  logic                       strobe,
  input  logic                       grid_en,
  output logic [ANODES-1:0]          anode_o,
  output logic [STAGES-ANODES-1:0]   grid_o,
  output logic                       dout
);

  localparam int GRIDS = STAGES - ANODES;

  logic [STAGES-1:0] sreg;
  logic [STAGES-1:0] lat;

  disp_shift_reg #(.STAGES(STAGES)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .sreg (sreg)
  );

  disp_latch_bank #(.WIDTH(STAGES)) u_latch (
    .clk (clk),
    .rst (rst),
    .le  (strobe),
    .d   (sreg),
    .q   (lat)
  );

  assign anode_o = lat[ANODES-1:0];

  disp_grid_gate #(.GRIDS(GRIDS)) u_grid (
    .en   (grid_en),
    .lat  (lat[STAGES-1:ANODES]),
    .grid (grid_o)
  );

  disp_cascade_out u_cas (
    .clk        (clk),
    .rst        (rst),
    .last_stage (sreg[STAGES-1]),
    .dout       (dout)
  );

  // R6: grids follow their latches only when enabled, otherwise stay off
  p_grid_gate_r6: assert property (@(posedge clk) disable iff (rst)
    grid_o == (grid_en ? lat[STAGES-1:ANODES] : {GRIDS{1'b0}}));

endmodule

// File: tb/tb_disp_serial_driver.sv
module tb_disp_serial_driver;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic strobe = 1'b0;
  logic grid_en = 1'b1;
  logic [28:0] anode_a, anode_b;
  logic [2:0]  grid_a, grid_b;
  logic dout_a, dout_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] chain = '0;
  logic [31:0] lat_a = '0;
  logic [31:0] lat_b = '0;

  disp_serial_driver dut (
    .clk(clk), .rst(rst), .din(din), .strobe(strobe), .grid_en(grid_en),
    .anode_o(anode_a), .grid_o(grid_a), .dout(dout_a)
  );

  disp_serial_driver dut_tail (
    .clk(clk), .rst(rst), .din(dout_a), .strobe(strobe), .grid_en(grid_en),
    .anode_o(anode_b), .grid_o(grid_b), .dout(dout_b)
  );

  task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check_eq({req, " anode near"}, 64'(anode_a), 64'(lat_a[28:0]));
    check_eq({req, " grid near"},  64'(grid_a), 64'(grid_en ? lat_a[31:29] : 3'b000));
    check_eq({req, " anode far"},  64'(anode_b), 64'(lat_b[28:0]));
    check_eq({req, " grid far"},   64'(grid_b), 64'(grid_en ? lat_b[31:29] : 3'b000));
  endtask

  // one clock pulse; model updated at the rising edge
  task automatic tick(input logic b);
    din = b;
    #HALF clk = 1'b1;
    chain = {chain[62:0], b};
    if (strobe) begin
      lat_a = chain[31:0];
      lat_b = chain[63:32];
    end
    #HALF clk = 1'b0;
    #1;
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1;
    #1;
    lat_a = chain[31:0];
    lat_b = chain[63:32];
    #HALF strobe = 1'b0;
    #1;
  endtask

  task automatic shift_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) tick(w[i]);
  endtask

  task automatic test_reset();
    #1;
    check_outputs("R2 during reset");
    check_eq("R2 dout near", 64'(dout_a), 64'd0);
    check_eq("R2 dout far", 64'(dout_b), 64'd0);
    rst = 1'b0;
    #1;
    check_outputs("R2 after release");
  endtask

  task automatic test_load_and_map();
    shift_word(32'hA5C3_0F96);
    check_outputs("R3 no strobe yet");
    pulse_strobe();
    check_eq("R5 anode mapping", 64'(anode_a), 64'(29'h05C3_0F96));
    check_eq("R5 grid mapping", 64'(grid_a), 64'(3'b101));
    check_eq("R1 stage31 via dout", 64'(dout_a), 64'(1'b1));
    check_outputs("R5 after strobe");
  endtask

  task automatic test_hold();
    shift_word(32'h0123_4567);
    check_eq("R3 held anode", 64'(anode_a), 64'(29'h05C3_0F96));
    check_outputs("R3 hold");
  endtask

  task automatic test_transparent();
    strobe = 1'b1;
    #1;
    lat_a = chain[31:0];
    lat_b = chain[63:32];
    check_outputs("R4 strobe rise");
    tick(1'b1);
    check_outputs("R4 shift under strobe");
    tick(1'b0);
    check_outputs("R4 second shift");
    strobe = 1'b0;
    #1;
    tick(1'b1);
    check_outputs("R3 after strobe drop");
  endtask

  task automatic test_grid_en();
    shift_word(32'hFFFF_FFFF);
    pulse_strobe();
    grid_en = 1'b0;
    #1;
    check_eq("R6 grids off", 64'(grid_a), 64'd0);
    check_eq("R6 anodes kept", 64'(anode_a), 64'(29'h1FFF_FFFF));
    grid_en = 1'b1;
    #1;
    check_eq("R6 grids on", 64'(grid_a), 64'(3'b111));
  endtask

  task automatic test_dout_timing();
    logic old;
    shift_word(32'h8000_0000);
    check_eq("R7 dout after falling edge", 64'(dout_a), 64'(chain[31]));
    old = chain[31];
    din = 1'b0;
    #HALF clk = 1'b1;
    chain = {chain[62:0], 1'b0};
    #1;
    check_eq("R7 dout before falling edge", 64'(dout_a), 64'(old));
    #(HALF - 1) clk = 1'b0;
    #1;
    check_eq("R7 dout updated", 64'(dout_a), 64'(chain[31]));
  endtask

  task automatic test_cascade();
    shift_word(32'h1234_5678);
    shift_word(32'hDEAD_BEEF);
    pulse_strobe();
    check_eq("R8 far anode", 64'(anode_b), 64'(29'h1234_5678 & 29'h1FFF_FFFF));
    check_eq("R8 far grid", 64'(grid_b), 64'(3'b000));
    check_eq("R8 near anode", 64'(anode_a), 64'(29'h1EAD_BEEF));
    check_eq("R8 near grid", 64'(grid_a), 64'(3'b110));
    check_eq("R8 far dout", 64'(dout_b), 64'(1'b0));
    check_outputs("R8 chain");
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_load_and_map();
    test_hold();
    test_transparent();
    test_grid_en();
    test_dout_timing();
    test_cascade();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule